// File: doc/BRIEF.md
# Horizontal-Sync Line-Lock Phase Comparator

This block is the clocked core of a loop that locks a pixel clock to the horizontal sync of an incoming video signal. It runs on the recovered pixel clock. A programmable divider counts out twice a video line length and emits one feedback tick per wrap. Instead of that tick, the loop can use an external divided-clock input. The block measures how far apart the sync rising edge and the feedback edge are. It then asks an external loop filter to raise or lower the oscillator frequency, with a pulse whose length equals that separation.

A two-bit mode input selects normal tracking, fast acquisition or coast. Fast acquisition raises a gain-boost flag together with the pump request. Coast silences the pump. After several consecutive lines with well-aligned edges the loop counts as locked. From then on the pump is silent, and the active-low lock indicator stays low. While unlocked, the indicator gives one high pulse per measured line.

Top module: `hlock_phase_core`

## Requirements
- R1: With `div_sel_i` high, `fb_out_o` pulses high for one clock every 2N clocks. N is chosen by `prog_i` (bit 2 most significant): 000:1702, 001:1728, 010:1888, 011:2270, 100:1364, 101:1716, 110:1560, 111:1820.
- R2: With `div_sel_i` low, `fb_out_o` stays low and the rising edges of `ext_fb_i` serve as feedback. With it high, the internal tick is the feedback.
- R3: When the sync edge comes d clocks before the feedback edge, `pump_up_o` goes high for exactly d consecutive clocks and `pump_dn_o` stays low.
- R4: When the feedback edge comes d clocks before the sync edge, `pump_dn_o` goes high for exactly d clocks and `pump_up_o` stays low. Coincident edges (d = 0) produce no pump pulse.
- R5: The pump pulse length is capped at 255 clocks, whatever the separation.
- R6: A second edge of the same kind that arrives before the opposite edge restarts the measurement from that second edge.
- R7: Mode codes 10 and 11 (coast) keep both pump outputs low from the next clock on, and they also cut short a pulse already in progress.
- R8: Mode 01 (fast lock) raises `boost_o` on exactly the clocks on which a pump output is high. In other modes `boost_o` stays low.
- R9: A line is in the window when its separation is at most 2 clocks. After 4 consecutive lines in the window the loop is locked, and that line and later ones produce no pump pulse. While unlocked, `lock_n_o` pulses high for one clock per measured line. While locked, it stays low.
- R10: The first line outside the window clears lock. That line's pump pulse and its `lock_n_o` pulse are both produced.
- R11: Synchronous reset clears the divider, drives both pump outputs, `boost_o` and `fb_out_o` low, and holds `lock_n_o` high.
- R12: `pump_up_o` and `pump_dn_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| prog_i | input | 3 | Line-length select |
| div_sel_i | input | 1 | 1: internal divider feedback, 0: external feedback |
| mode_i | input | 2 | 00 normal, 01 fast lock, 10/11 coast |
| hsync_i | input | 1 | Horizontal sync, asynchronous, rising edge used |
| ext_fb_i | input | 1 | External divided-clock feedback, rising edge used |
| pump_up_o | output | 1 | Request to raise oscillator frequency |
| pump_dn_o | output | 1 | Request to lower oscillator frequency |
| boost_o | output | 1 | Gain boost, fast-lock mode only |
| lock_n_o | output | 1 | Low when locked, one-clock high pulse per unlocked line |
| fb_out_o | output | 1 | Internal divider tick, for test |

## Verification
The hardest state to reach from the ports is lock and its loss. Lock needs an unbroken run of lines whose edges land within two clocks of each other, and with the internal divider a line is thousands of clocks long. The bench therefore runs most lines in external-feedback mode. It places the sync and feedback edges through identical synchronizers at chosen offsets, so that each line is short and its separation is exact. A sweep over separations 0 to 40 in both directions walks through a run of small offsets that reaches lock and then breaks it. A bench model of the consecutive-line counter predicts every pump length and indicator pulse.

// File: rtl/hlock_pkg.sv
package hlock_pkg;

  localparam int unsigned LEN_W  = 12;
  localparam int unsigned PROG_W = 3;

  typedef enum logic [1:0] {
    PM_IDLE      = 2'd0,
    PM_WAIT_FB   = 2'd1,
    PM_WAIT_SYNC = 2'd2
  } pm_state_t;

  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_FAST   = 2'b01;

  // Video line lengths in pixel clocks, indexed by the program select.
  function automatic logic [LEN_W-1:0] line_len(input logic [PROG_W-1:0] sel);
    logic [LEN_W-1:0] n;
    case (sel)
      3'b000:  n = 12'd1702;
      3'b001:  n = 12'd1728;
      3'b010:  n = 12'd1888;
      3'b011:  n = 12'd2270;
      3'b100:  n = 12'd1364;
      3'b101:  n = 12'd1716;
      3'b110:  n = 12'd1560;
      default: n = 12'd1820;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hlock_edge_sync.sv
module hlock_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  // Synchronizer stages plus one history flop for edge detection.
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/hlock_line_div.sv
module hlock_line_div
  import hlock_pkg::*;
#(
  parameter int unsigned CNT_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [PROG_W-1:0] prog_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             tick_q;

  // Count runs 0 .. 2N-1; ">=" keeps it bounded when the program shrinks.
  assign last = CNT_W'({line_len(prog_i), 1'b0}) - CNT_W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/hlock_phase_meas.sv
module hlock_phase_meas
  import hlock_pkg::*;
#(
  parameter int unsigned SEP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sync_edge_i,
  input  logic             fb_edge_i,
  output logic             meas_v_o,
  output logic             meas_up_o,
  output logic [SEP_W-1:0] meas_sep_o
);
  localparam logic [SEP_W-1:0] SEP_MAX = {SEP_W{1'b1}};

  pm_state_t        st_q;
  logic [SEP_W-1:0] gap_q;
  logic [SEP_W-1:0] gap_inc;
  logic             v_q, up_q;
  logic [SEP_W-1:0] sep_q;

  assign gap_inc = (gap_q == SEP_MAX) ? SEP_MAX : gap_q + SEP_W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q  <= PM_IDLE;
      gap_q <= '0;
      v_q   <= 1'b0;
      up_q  <= 1'b0;
      sep_q <= '0;
    end else begin
      v_q <= 1'b0;
      case (st_q)
        PM_IDLE: begin
          if (sync_edge_i && fb_edge_i) begin
            v_q   <= 1'b1;
            up_q  <= 1'b1;
            sep_q <= '0;
          end else if (sync_edge_i) begin
            st_q  <= PM_WAIT_FB;
            gap_q <= SEP_W'(1);
          end else if (fb_edge_i) begin
            st_q  <= PM_WAIT_SYNC;
            gap_q <= SEP_W'(1);
          end
        end
        PM_WAIT_FB: begin
          if (fb_edge_i) begin
            v_q   <= 1'b1;
            up_q  <= 1'b1;
            sep_q <= gap_q;
            st_q  <= PM_IDLE;
          end else if (sync_edge_i) begin
            gap_q <= SEP_W'(1);
          end else begin
            gap_q <= gap_inc;
          end
        end
        PM_WAIT_SYNC: begin
          if (sync_edge_i) begin
            v_q   <= 1'b1;
            up_q  <= 1'b0;
            sep_q <= gap_q;
            st_q  <= PM_IDLE;
          end else if (fb_edge_i) begin
            gap_q <= SEP_W'(1);
          end else begin
            gap_q <= gap_inc;
          end
        end
        default: st_q <= PM_IDLE;
      endcase
    end
  end

  assign meas_v_o   = v_q;
  assign meas_up_o  = up_q;
  assign meas_sep_o = sep_q;
endmodule

// File: rtl/hlock_loop_ctl.sv
module hlock_loop_ctl
  import hlock_pkg::*;
#(
  parameter int unsigned SEP_W      = 8,
  parameter int unsigned LOCK_WIN   = 2,
  parameter int unsigned LOCK_LINES = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       mode_i,
  input  logic             meas_v_i,
  input  logic             meas_up_i,
  input  logic [SEP_W-1:0] meas_sep_i,
  output logic             pump_up_o,
  output logic             pump_dn_o,
  output logic             boost_o,
  output logic             lock_n_o
);
  localparam int unsigned GOOD_W = $clog2(LOCK_LINES + 1);

  logic [GOOD_W-1:0] good_q, good_nxt;
  logic              in_win, locked_nxt;
  logic [SEP_W-1:0]  left_q, left_nxt;
  logic              dir_q, dir_nxt;
  logic              coast, fast;
  logic              up_q, dn_q, boost_q, lock_n_q;

  assign coast  = mode_i[1];
  assign fast   = (mode_i == MODE_FAST);
  assign in_win = (meas_sep_i <= SEP_W'(LOCK_WIN));

  always_comb begin
    good_nxt = good_q;
    if (meas_v_i) begin
      if (!in_win)                              good_nxt = '0;
      else if (good_q != GOOD_W'(LOCK_LINES))   good_nxt = good_q + GOOD_W'(1);
    end
  end

  assign locked_nxt = (good_nxt == GOOD_W'(LOCK_LINES));

  always_comb begin
    left_nxt = left_q;
    dir_nxt  = dir_q;
    if (coast) begin
      left_nxt = '0;
    end else if (meas_v_i) begin
      left_nxt = locked_nxt ? '0 : meas_sep_i;
      dir_nxt  = meas_up_i;
    end else if (left_q != '0) begin
      left_nxt = left_q - SEP_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      good_q   <= '0;
      left_q   <= '0;
      dir_q    <= 1'b0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      boost_q  <= 1'b0;
      lock_n_q <= 1'b1;
    end else begin
      good_q   <= good_nxt;
      left_q   <= left_nxt;
      dir_q    <= dir_nxt;
      up_q     <= (left_nxt != '0) &&  dir_nxt;
      dn_q     <= (left_nxt != '0) && !dir_nxt;
      boost_q  <= (left_nxt != '0) && fast;
      lock_n_q <= meas_v_i && !locked_nxt;
    end
  end

  assign pump_up_o = up_q;
  assign pump_dn_o = dn_q;
  assign boost_o   = boost_q;
  assign lock_n_o  = lock_n_q;
endmodule

// File: rtl/hlock_phase_core.sv
module hlock_phase_core
  import hlock_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEP_W       = 8,
  parameter int unsigned LOCK_WIN    = 2,
  parameter int unsigned LOCK_LINES  = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] prog_i,
  input  logic       div_sel_i,
  input  logic [1:0] mode_i,
  input  logic       hsync_i,
  input  logic       ext_fb_i,
  output logic       pump_up_o,
  output logic       pump_dn_o,
  output logic       boost_o,
  output logic       lock_n_o,
  output logic       fb_out_o
);
  logic             sync_rise, ext_rise, int_tick, fb_edge;
  logic             meas_v, meas_up;
  logic [SEP_W-1:0] meas_sep;

  hlock_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_hs (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(hsync_i), .rise_o(sync_rise)
  );

  // Same chain on external feedback so both edges see equal latency.
  hlock_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(ext_fb_i), .rise_o(ext_rise)
  );

  hlock_line_div u_div (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(div_sel_i),
    .prog_i(prog_i), .tick_o(int_tick)
  );

  assign fb_edge  = div_sel_i ? int_tick : ext_rise;
  assign fb_out_o = int_tick;

  hlock_phase_meas #(.SEP_W(SEP_W)) u_meas (
    .clk_i(clk_i), .rst_i(rst_i),
    .sync_edge_i(sync_rise), .fb_edge_i(fb_edge),
    .meas_v_o(meas_v), .meas_up_o(meas_up), .meas_sep_o(meas_sep)
  );

  hlock_loop_ctl #(
    .SEP_W(SEP_W), .LOCK_WIN(LOCK_WIN), .LOCK_LINES(LOCK_LINES)
  ) u_ctl (
    .clk_i(clk_i), .rst_i(rst_i), .mode_i(mode_i),
    .meas_v_i(meas_v), .meas_up_i(meas_up), .meas_sep_i(meas_sep),
    .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o),
    .boost_o(boost_o), .lock_n_o(lock_n_o)
  );
endmodule

// File: rtl/hlock_phase_core_chk.sv
module hlock_phase_core_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic [2:0] prog_i,
  input logic       div_sel_i,
  input logic [1:0] mode_i,
  input logic       hsync_i,
  input logic       ext_fb_i,
  input logic       pump_up_o,
  input logic       pump_dn_o,
  input logic       boost_o,
  input logic       lock_n_o,
  input logic       fb_out_o
);
  a_r12_one_pump: assert property (@(posedge clk_i) disable iff (rst_i)
    !(pump_up_o && pump_dn_o));

  a_r7_coast_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_i[1] |=> (!pump_up_o && !pump_dn_o));

  a_r8_boost_pumping: assert property (@(posedge clk_i) disable iff (rst_i)
    boost_o |-> (pump_up_o || pump_dn_o));

  a_r8_boost_fast: assert property (@(posedge clk_i) disable iff (rst_i)
    boost_o |-> ($past(mode_i) == 2'b01));

  a_r2_fbout_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !div_sel_i |=> !fb_out_o);

  a_r1_tick_single: assert property (@(posedge clk_i) disable iff (rst_i)
    fb_out_o |=> !fb_out_o);

  a_r9_lock_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    lock_n_o |=> !lock_n_o);

  a_r11_reset_state: assert property (@(posedge clk_i)
    rst_i |=> (lock_n_o && !pump_up_o && !pump_dn_o && !boost_o && !fb_out_o));
endmodule

bind hlock_phase_core hlock_phase_core_chk u_chk (.*);

// File: tb/tb_hlock_phase_core.sv
module tb_hlock_phase_core;
  localparam time TCLK = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [2:0] prog_i = 3'b000;
  logic       div_sel_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       hsync_i = 1'b0;
  logic       ext_fb_i = 1'b0;
  logic       pump_up_o, pump_dn_o, boost_o, lock_n_o, fb_out_o;

  hlock_phase_core dut (.*);

  always #(TCLK/2) clk_i = ~clk_i;

  int n_vec = 0, n_bad = 0;
  int c_up, c_dn, c_boost, c_lock, c_fb, c_both;
  int good = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp_v);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp_v);
    end
  endtask

  function automatic int line_n(input int sel);
    case (sel)
      0: return 1702; 1: return 1728; 2: return 1888; 3: return 2270;
      4: return 1364; 5: return 1716; 6: return 1560; default: return 1820;
    endcase
  endfunction

  // Window counter of consecutive well-aligned lines; returns lock state.
  function automatic bit model_line(input int sep);
    if (sep <= 2) good = (good < 4) ? good + 1 : 4;
    else          good = 0;
    return good >= 4;
  endfunction

  task automatic run_drive(input int sa, input int sb, input int fa, input int fb2,
                           input int cut_at, input logic [1:0] md,
                           input logic [1:0] md_cut, input int len);
    c_up = 0; c_dn = 0; c_boost = 0; c_lock = 0; c_fb = 0; c_both = 0;
    mode_i = md;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      c_up    += int'(pump_up_o);
      c_dn    += int'(pump_dn_o);
      c_boost += int'(boost_o);
      c_lock  += int'(lock_n_o);
      c_fb    += int'(fb_out_o);
      if (pump_up_o && pump_dn_o) c_both++;
      hsync_i  = (i == sa) || (i == sb);
      ext_fb_i = (i == fa) || (i == fb2);
      if (i == cut_at) mode_i = md_cut;
    end
    hsync_i = 1'b0;
    ext_fb_i = 1'b0;
    mode_i = md;
  endtask

  task automatic check_counts(input string tag, input int eu, input int ed,
                              input int eb, input int el, input int ef);
    chk(c_up == eu,    {tag, " pump-up clocks"}, c_up, eu);
    chk(c_dn == ed,    {tag, " pump-down clocks"}, c_dn, ed);
    chk(c_boost == eb, {tag, " R8 boost clocks"}, c_boost, eb);
    chk(c_lock == el,  {tag, " R9 lock_n pulses"}, c_lock, el);
    chk(c_fb == ef,    {tag, " R2 fb_out pulses"}, c_fb, ef);
    chk(c_both == 0,   {tag, " R12 both pumps"}, c_both, 0);
  endtask

  task automatic line(input bit sync_first, input int d, input logic [1:0] md,
                      input string tag);
    int sep, w, len;
    bit lk;
    sep = (d > 255) ? 255 : d;
    lk  = model_line(sep);
    w   = (md[1] || lk) ? 0 : sep;
    len = d + sep + 14;
    if (sync_first) run_drive(0, -1, d, -1, -1, md, md, len);
    else            run_drive(d, -1, 0, -1, -1, md, md, len);
    check_counts(tag, sync_first ? w : 0, sync_first ? 0 : w,
                 (md == 2'b01) ? w : 0, lk ? 0 : 1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d cycles", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int gap;
    bit lk;
    // R11: state while reset is held.
    repeat (3) @(negedge clk_i);
    chk(lock_n_o == 1'b1, "R11 lock_n in reset", int'(lock_n_o), 1);
    chk(!pump_up_o && !pump_dn_o, "R11 pumps in reset",
        int'(pump_up_o) + int'(pump_dn_o), 0);
    chk(!boost_o && !fb_out_o, "R11 boost/fb in reset",
        int'(boost_o) + int'(fb_out_o), 0);
    rst_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // R3/R4 sweep with external feedback; small offsets build lock (R9), d=3 breaks it (R10).
    for (int d = 0; d <= 40; d++) begin
      line(1'b1, d, (d % 2 == 1) ? 2'b01 : 2'b00, (d <= 3) ? "R3 R9 R10" : "R3");
      line(1'b0, d, (d % 3 == 1) ? 2'b01 : 2'b00, (d <= 3) ? "R4 R9 R10" : "R4");
    end

    // R9/R10 again: explicit run into lock, then loss.
    for (int k = 0; k < 5; k++) line(k % 2 == 0, 2, 2'b00, "R9 lock run");
    line(1'b1, 6, 2'b00, "R10 lock loss");
    line(1'b0, 1, 2'b01, "R10 after loss");

    // R5 cap.
    line(1'b1, 254, 2'b00, "R5");
    line(1'b1, 255, 2'b00, "R5");
    line(1'b0, 256, 2'b00, "R5");
    line(1'b0, 300, 2'b01, "R5");

    // R6 restart by repeated edge.
    run_drive(0, 10, 13, -1, -1, 2'b00, 2'b00, 40);
    lk = model_line(3);
    check_counts("R6 sync restart", 3, 0, 0, 1, 0);
    run_drive(12, -1, 0, 8, -1, 2'b00, 2'b00, 40);
    lk = model_line(4);
    check_counts("R6 fb restart", 0, 4, 0, 1, 0);

    // R7 coast codes and cut of a running pulse.
    line(1'b1, 10, 2'b10, "R7 coast 10");
    line(1'b0, 7, 2'b11, "R7 coast 11");
    run_drive(0, -1, 100, -1, 130, 2'b00, 2'b10, 400);
    lk = model_line(100);
    check_counts("R7 coast cut", 27, 0, 0, 1, 0);
    mode_i = 2'b00;

    // R1 divider period for every program code.
    div_sel_i = 1'b1;
    for (int c = 0; c < 8; c++) begin
      prog_i = 3'(c);
      gap = 0;
      while (gap < 6000) begin
        @(negedge clk_i);
        gap++;
        if (fb_out_o) break;
      end
      gap = 0;
      while (gap < 6000) begin
        @(negedge clk_i);
        gap++;
        if (fb_out_o) break;
      end
      chk(gap == 2 * line_n(c), $sformatf("R1 period code %0d", c), gap, 2 * line_n(c));
    end

    // R2/R4 internal feedback: sync 20 drive slots after the tick is seen.
    prog_i = 3'b100;
    gap = 0;
    while (gap < 6000) begin
      @(negedge clk_i);
      gap++;
      if (fb_out_o) break;
    end
    run_drive(20, -1, -1, -1, -1, 2'b00, 2'b00, 60);
    lk = model_line(23);
    check_counts("R2 R4 internal fb", 0, 23, 0, 1, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule